// File: doc/BRIEF.md
# Receive Transaction Packet Router

This block sits behind the link receive path and decides, for every incoming transaction-layer packet, where the packet goes. A header of three or four dwords arrives with a one-cycle valid strobe. Any payload follows on later cycles as a beat stream with start and end markers. The block classifies the header and steers the header and all of its payload to exactly one destination:

- the application receive port, for memory and I/O requests that hit a base address register (BAR);
- the internal configuration handler, for type 0 configuration requests;
- the internal message handler, for power management and slot power limit messages;
- a discard path, for everything else.

The BAR table is fixed by parameters. Each BAR has a base, a size mask and a memory/I-O kind. A packet that lands on the discard path produces no header or payload output at all. When the dropped packet is non-posted or is a message, the block raises a one-cycle error pulse. When it is non-posted, the block also raises a completion request. Building the completion, credit accounting and link-layer work are handled elsewhere.

Header outputs appear one clock after the header strobe. Each payload beat appears one clock after its input beat. The routing decision made at the header is held until the end-of-packet beat.

Top module: `rx_pkt_router`

## Requirements
- R1: The header's fmt/type is in dw0 bits [30:24]: bit 30 is has-data, bit 29 is the four-dword form, and bits [28:24] are the type. Type 00000 is memory and 00010 is I/O. Such a request is forwarded when its address matches a BAR of the same kind, meaning (addr XOR base) AND mask is zero. It is then presented on the application header port one cycle after the strobe, with appBarHit one-hot on the lowest matching BAR index. A memory request never matches an I/O BAR, and an I/O request never matches a memory BAR.
- R2: In the three-dword form the address is dw2[31:2] with the upper 32 bits zero. In the four-dword form the address is {dw2, dw3[31:2]}, and all 64 bits take part in the BAR compare.
- R3: A type 00100 (configuration type 0) request goes only to the configuration header port, never to the application port.
- R4: A message (type 10rrr) whose code in dw1[7:0] is 0x14, 0x18, 0x19, 0x1B or 0x50 goes only to the message header port.
- R5: Every other packet is dropped. This includes unmatched memory or I/O requests, configuration type 1, other message codes and other types. No header output and no payload beat of a dropped packet appears on any port.
- R6: urErr pulses for exactly one cycle, one clock after the header strobe, when a dropped packet is non-posted or is a message. A dropped memory write gives no pulse.
- R7: cplReq pulses together with urErr only for a dropped non-posted request. Non-posted means a memory read, an I/O read or write, or a configuration type 0 or 1 request. A dropped message gives no cplReq.
- R8: After a header with has-data set, each payload beat is presented one cycle later on the beat port of the same destination, with data and sop/eop unchanged. The decision lasts through the eop beat. A beat arriving while no decision is held is discarded.
- R9: An eop beat and the next header may arrive in the same cycle. The beat then goes to the old destination and the new header starts a new decision.
- R10: Out of reset all valid, pulse and hit outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hdrValid | input | 1 | Header strobe, one cycle per packet |
| hdrData | input | 128 | Header; dw0 in bits [31:0], dw3 in [127:96] |
| beatValid | input | 1 | Payload beat valid |
| beatSop | input | 1 | First payload beat |
| beatEop | input | 1 | Last payload beat |
| beatData | input | DATA_W | Payload beat data |
| hdrOut | output | 128 | Registered header for the selected destination |
| appHdrValid | output | 1 | Header valid, application port |
| appBarHit | output | NUM_BAR | One-hot matching BAR for the application header |
| cfgHdrValid | output | 1 | Header valid, configuration handler |
| msgHdrValid | output | 1 | Header valid, message handler |
| beatOut | output | DATA_W | Registered payload beat |
| beatOutSop | output | 1 | Start marker of the forwarded beat |
| beatOutEop | output | 1 | End marker of the forwarded beat |
| appBeatValid | output | 1 | Beat valid, application port |
| cfgBeatValid | output | 1 | Beat valid, configuration handler |
| msgBeatValid | output | 1 | Beat valid, message handler |
| urErr | output | 1 | Unsupported-request error pulse |
| cplReq | output | 1 | Request to generate a completion |

## Verification
Requests are sent at addresses just inside and just outside a BAR, and with a four-dword address that differs only in its upper word. These patterns separate a correct mask compare from one that drops the high half or mis-sizes a window. The same address is also sent as a memory and as an I/O request, which shows whether the BAR kind is honoured. Message codes from the accepted set are sent next to a rejected one, and configuration type 0 next to type 1, to separate internal absorption from an unsupported drop. Finally, dropped posted writes, stray beats, header-only packets and an eop arriving with the next header show that payload follows its own header's decision and that nothing leaks out of the discard path.

// File: rtl/rx_route_pkg.sv
package rx_route_pkg;
  localparam int HDR_W = 128;

  typedef enum logic [1:0] {
    DEST_APP  = 2'd0,
    DEST_CFG  = 2'd1,
    DEST_MSG  = 2'd2,
    DEST_DROP = 2'd3
  } dest_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic  hdrTake;
    dest_e hdrDest;
    logic  beatTake;
    dest_e beatDest;
  } route_strb_t;

  localparam logic [4:0] TYPE_MEM  = 5'b00000;
  localparam logic [4:0] TYPE_IO   = 5'b00010;
  localparam logic [4:0] TYPE_CFG0 = 5'b00100;
  localparam logic [4:0] TYPE_CFG1 = 5'b00101;

  function automatic logic msgCodeOk(input logic [7:0] code);
    return (code == 8'h14) || (code == 8'h18) || (code == 8'h19) ||
           (code == 8'h1B) || (code == 8'h50);
  endfunction
endpackage

// File: rtl/rx_route_ctrl.sv
module rx_route_ctrl
  import rx_route_pkg::*;
#(
  parameter int NUM_BAR = 3,
  parameter logic [NUM_BAR*64-1:0] BAR_BASE = '0,
  parameter logic [NUM_BAR*64-1:0] BAR_MASK = '0,
  parameter logic [NUM_BAR-1:0]    BAR_IO   = '0
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               hdrValid,
  input  logic [6:0]         fmtType,
  input  logic [7:0]         msgCode,
  input  logic [63:0]        addrWords,
  input  logic               beatValid,
  input  logic               beatEop,
  output route_strb_t        strb,
  output logic [NUM_BAR-1:0] barHit,
  output logic               urErr,
  output logic               cplReq
);
  logic        hasData, is4dw, isMem, isIo, isCfg0, isCfg1, isMsg, nonPosted;
  logic [4:0]  typ;
  logic [63:0] addr;
  logic [NUM_BAR-1:0] barMatch;
  dest_e       hdrDest, routeDest;
  logic        routeActive;
  logic        unusedDw3Low;

  assign unusedDw3Low = ^addrWords[33:32];

  assign hasData = fmtType[6];
  assign is4dw   = fmtType[5];
  assign typ     = fmtType[4:0];
  assign isMem   = (typ == TYPE_MEM);
  assign isIo    = (typ == TYPE_IO);
  assign isCfg0  = (typ == TYPE_CFG0);
  assign isCfg1  = (typ == TYPE_CFG1);
  assign isMsg   = (typ[4:3] == 2'b10);
  assign nonPosted = (isMem && !hasData) || isIo || isCfg0 || isCfg1;

  assign addr = is4dw ? {addrWords[31:0], addrWords[63:34], 2'b00}
                      : {32'h0, addrWords[31:2], 2'b00};

  for (genvar i = 0; i < NUM_BAR; i++) begin : gBar
    assign barMatch[i] = (((addr ^ BAR_BASE[i*64 +: 64]) & BAR_MASK[i*64 +: 64]) == 64'h0)
                         && (BAR_IO[i] ? isIo : isMem);
  end

  // lowest index wins
  assign barHit = barMatch & (~barMatch + {{(NUM_BAR-1){1'b0}}, 1'b1});

  always_comb begin
    if ((isMem || isIo) && (|barMatch)) hdrDest = DEST_APP;
    else if (isCfg0)                    hdrDest = DEST_CFG;
    else if (isMsg && msgCodeOk(msgCode)) hdrDest = DEST_MSG;
    else                                hdrDest = DEST_DROP;
  end

  always_comb begin
    strb.hdrTake  = hdrValid;
    strb.hdrDest  = hdrDest;
    strb.beatTake = beatValid && routeActive;
    strb.beatDest = routeDest;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      routeActive <= 1'b0;
      routeDest   <= DEST_DROP;
      urErr       <= 1'b0;
      cplReq      <= 1'b0;
    end else begin
      if (beatValid && beatEop) routeActive <= 1'b0;
      if (hdrValid) begin
        routeActive <= hasData;
        routeDest   <= hdrDest;
      end
      urErr  <= hdrValid && (hdrDest == DEST_DROP) && (nonPosted || isMsg);
      cplReq <= hdrValid && (hdrDest == DEST_DROP) && nonPosted;
    end
  end
endmodule

// File: rtl/rx_route_dp.sv
module rx_route_dp
  import rx_route_pkg::*;
#(
  parameter int DATA_W  = 64,
  parameter int NUM_BAR = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  route_strb_t        strb,
  input  logic [HDR_W-1:0]   hdrData,
  input  logic [NUM_BAR-1:0] barHit,
  input  logic               beatSop,
  input  logic               beatEop,
  input  logic [DATA_W-1:0]  beatData,
  output logic [HDR_W-1:0]   hdrOut,
  output logic               appHdrValid,
  output logic [NUM_BAR-1:0] appBarHit,
  output logic               cfgHdrValid,
  output logic               msgHdrValid,
  output logic [DATA_W-1:0]  beatOut,
  output logic               beatOutSop,
  output logic               beatOutEop,
  output logic               appBeatValid,
  output logic               cfgBeatValid,
  output logic               msgBeatValid
);
  logic hdrFwd, beatFwd;

  assign hdrFwd  = strb.hdrTake  && (strb.hdrDest  != DEST_DROP);
  assign beatFwd = strb.beatTake && (strb.beatDest != DEST_DROP);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hdrOut       <= '0;
      appHdrValid  <= 1'b0;
      appBarHit    <= '0;
      cfgHdrValid  <= 1'b0;
      msgHdrValid  <= 1'b0;
      beatOut      <= '0;
      beatOutSop   <= 1'b0;
      beatOutEop   <= 1'b0;
      appBeatValid <= 1'b0;
      cfgBeatValid <= 1'b0;
      msgBeatValid <= 1'b0;
    end else begin
      appHdrValid <= hdrFwd && (strb.hdrDest == DEST_APP);
      cfgHdrValid <= hdrFwd && (strb.hdrDest == DEST_CFG);
      msgHdrValid <= hdrFwd && (strb.hdrDest == DEST_MSG);
      appBarHit   <= (hdrFwd && (strb.hdrDest == DEST_APP)) ? barHit : '0;
      if (hdrFwd) hdrOut <= hdrData;

      appBeatValid <= beatFwd && (strb.beatDest == DEST_APP);
      cfgBeatValid <= beatFwd && (strb.beatDest == DEST_CFG);
      msgBeatValid <= beatFwd && (strb.beatDest == DEST_MSG);
      beatOutSop   <= beatFwd && beatSop;
      beatOutEop   <= beatFwd && beatEop;
      if (beatFwd) beatOut <= beatData;
    end
  end
endmodule

// File: rtl/rx_pkt_router.sv
module rx_pkt_router
  import rx_route_pkg::*;
#(
  parameter int DATA_W  = 64,
  parameter int NUM_BAR = 3,
  parameter logic [NUM_BAR*64-1:0] BAR_BASE = {64'h0000_0000_0000_1000,
                                               64'h0000_0010_0000_0000,
                                               64'h0000_0000_8000_0000},
  parameter logic [NUM_BAR*64-1:0] BAR_MASK = {64'hFFFF_FFFF_FFFF_FF00,
                                               64'hFFFF_FFFF_FFF0_0000,
                                               64'hFFFF_FFFF_FFFF_F000},
  parameter logic [NUM_BAR-1:0]    BAR_IO   = 3'b100
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               hdrValid,
  input  logic [127:0]       hdrData,
  input  logic               beatValid,
  input  logic               beatSop,
  input  logic               beatEop,
  input  logic [DATA_W-1:0]  beatData,
  output logic [127:0]       hdrOut,
  output logic               appHdrValid,
  output logic [NUM_BAR-1:0] appBarHit,
  output logic               cfgHdrValid,
  output logic               msgHdrValid,
  output logic [DATA_W-1:0]  beatOut,
  output logic               beatOutSop,
  output logic               beatOutEop,
  output logic               appBeatValid,
  output logic               cfgBeatValid,
  output logic               msgBeatValid,
  output logic               urErr,
  output logic               cplReq
);
  route_strb_t        strb;
  logic [NUM_BAR-1:0] barHit;

  rx_route_ctrl #(
    .NUM_BAR(NUM_BAR), .BAR_BASE(BAR_BASE), .BAR_MASK(BAR_MASK), .BAR_IO(BAR_IO)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .hdrValid(hdrValid),
    .fmtType(hdrData[30:24]), .msgCode(hdrData[39:32]), .addrWords(hdrData[127:64]),
    .beatValid(beatValid), .beatEop(beatEop),
    .strb(strb), .barHit(barHit), .urErr(urErr), .cplReq(cplReq)
  );

  rx_route_dp #(.DATA_W(DATA_W), .NUM_BAR(NUM_BAR)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .hdrData(hdrData), .barHit(barHit),
    .beatSop(beatSop), .beatEop(beatEop), .beatData(beatData),
    .hdrOut(hdrOut), .appHdrValid(appHdrValid), .appBarHit(appBarHit),
    .cfgHdrValid(cfgHdrValid), .msgHdrValid(msgHdrValid),
    .beatOut(beatOut), .beatOutSop(beatOutSop), .beatOutEop(beatOutEop),
    .appBeatValid(appBeatValid), .cfgBeatValid(cfgBeatValid), .msgBeatValid(msgBeatValid)
  );
endmodule

// File: rtl/rx_route_chk.sv
module rx_route_chk
  import rx_route_pkg::*;
#(
  parameter int NUM_BAR = 3
) (
  input logic               clk,
  input logic               rstN,
  input logic               hdrValid,
  input logic               beatValid,
  input logic [4:0]         outType,
  input logic [7:0]         outCode,
  input logic               appHdrValid,
  input logic [NUM_BAR-1:0] appBarHit,
  input logic               cfgHdrValid,
  input logic               msgHdrValid,
  input logic               appBeatValid,
  input logic               cfgBeatValid,
  input logic               msgBeatValid,
  input logic               urErr,
  input logic               cplReq
);
  // R1
  app_one_bar_chk: assert property (@(posedge clk) disable iff (!rstN)
    appHdrValid |-> ($countones(appBarHit) == 1));

  // R1
  hdr_from_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    (appHdrValid || cfgHdrValid || msgHdrValid) |-> $past(hdrValid));

  // R3
  cfg_type_chk: assert property (@(posedge clk) disable iff (!rstN)
    cfgHdrValid |-> (outType == 5'b00100));

  // R4
  msg_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    msgHdrValid |-> ((outType[4:3] == 2'b10) && msgCodeOk(outCode)));

  // R5
  ur_no_forward_chk: assert property (@(posedge clk) disable iff (!rstN)
    urErr |-> !(appHdrValid || cfgHdrValid || msgHdrValid));

  // R6
  ur_from_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    urErr |-> $past(hdrValid));

  // R7
  cpl_with_ur_chk: assert property (@(posedge clk) disable iff (!rstN)
    cplReq |-> urErr);

  // R8
  beat_one_dest_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({appBeatValid, cfgBeatValid, msgBeatValid}));

  // R8
  beat_from_input_chk: assert property (@(posedge clk) disable iff (!rstN)
    (appBeatValid || cfgBeatValid || msgBeatValid) |-> $past(beatValid));
endmodule

bind rx_pkt_router rx_route_chk #(.NUM_BAR(NUM_BAR)) uChk (
  .clk(clk), .rstN(rstN), .hdrValid(hdrValid), .beatValid(beatValid),
  .outType(hdrOut[28:24]), .outCode(hdrOut[39:32]),
  .appHdrValid(appHdrValid), .appBarHit(appBarHit),
  .cfgHdrValid(cfgHdrValid), .msgHdrValid(msgHdrValid),
  .appBeatValid(appBeatValid), .cfgBeatValid(cfgBeatValid), .msgBeatValid(msgBeatValid),
  .urErr(urErr), .cplReq(cplReq)
);

// File: tb/sim_rx_pkt_router.sv
`timescale 1ns/1ps
module sim_rx_pkt_router;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         hdrValid = 1'b0;
  logic [127:0] hdrData = '0;
  logic         beatValid = 1'b0, beatSop = 1'b0, beatEop = 1'b0;
  logic [63:0]  beatData = '0;
  logic [127:0] hdrOut;
  logic         appHdrValid, cfgHdrValid, msgHdrValid;
  logic [2:0]   appBarHit;
  logic [63:0]  beatOut;
  logic         beatOutSop, beatOutEop, appBeatValid, cfgBeatValid, msgBeatValid;
  logic         urErr, cplReq;

  always #2 clk = ~clk;

  rx_pkt_router u0 (.*);

  typedef struct {
    logic [2:0]   hv;   // {msg,cfg,app}
    logic [2:0]   bar;
    logic [127:0] hdr;
    logic [2:0]   bv;   // {msg,cfg,app}
    logic         sop, eop;
    logic [63:0]  data;
    logic         ur, cpl;
    string        req;
  } ev_t;

  ev_t expQ[$];
  int  nChecks = 0, nFails = 0, cyc = 0;

  function automatic ev_t blankEv(string req);
    ev_t e;
    e.hv = '0; e.bar = '0; e.hdr = '0; e.bv = '0; e.sop = 0; e.eop = 0;
    e.data = '0; e.ur = 0; e.cpl = 0; e.req = req;
    return e;
  endfunction

  function automatic logic [127:0] mkHdr(logic [31:0] d0, logic [31:0] d1,
                                         logic [31:0] d2, logic [31:0] d3);
    return {d3, d2, d1, d0};
  endfunction

  function automatic logic [63:0] beatPat(logic [127:0] h, int i);
    return {h[31:0] ^ 32'hA5A5_0000, 32'(i) + 32'h1000};
  endfunction

  // dest: 0 app, 1 cfg, 2 msg, 3 drop
  task automatic sendPkt(logic [127:0] h, int nb, int dest, logic [2:0] bar,
                         logic ur, logic cpl, string req);
    ev_t e;
    @(negedge clk);
    hdrValid = 1'b1; hdrData = h;
    e = blankEv(req);
    if (dest < 3) begin
      e.hv = 3'b001 << dest; e.hdr = h;
      if (dest == 0) e.bar = bar;
    end
    e.ur = ur; e.cpl = cpl;
    if (dest < 3 || ur) expQ.push_back(e);
    for (int i = 0; i < nb; i++) begin
      @(negedge clk);
      hdrValid = 1'b0;
      beatValid = 1'b1; beatSop = (i == 0); beatEop = (i == nb - 1);
      beatData = beatPat(h, i);
      if (dest < 3) begin
        e = blankEv(req);
        e.bv = 3'b001 << dest; e.sop = (i == 0); e.eop = (i == nb - 1);
        e.data = beatPat(h, i);
        expQ.push_back(e);
      end
    end
    @(negedge clk);
    hdrValid = 1'b0; beatValid = 1'b0; beatSop = 1'b0; beatEop = 1'b0;
  endtask

  task automatic strayBeat();
    @(negedge clk);
    beatValid = 1'b1; beatSop = 1'b1; beatEop = 1'b1; beatData = 64'hDEAD_BEEF_0000_0001;
    @(negedge clk);
    beatValid = 1'b0; beatSop = 1'b0; beatEop = 1'b0;
  endtask

  // Monitor
  always @(negedge clk) begin
    if (rstN) begin
      ev_t a, x;
      a = blankEv("");
      a.hv = {msgHdrValid, cfgHdrValid, appHdrValid}; a.bar = appBarHit; a.hdr = hdrOut;
      a.bv = {msgBeatValid, cfgBeatValid, appBeatValid};
      a.sop = beatOutSop; a.eop = beatOutEop; a.data = beatOut;
      a.ur = urErr; a.cpl = cplReq;
      if (a.hv != 0 || a.bv != 0 || a.ur || a.cpl || a.bar != 0) begin
        nChecks++;
        if (expQ.size() == 0) begin
          nFails++;
          $display("FAIL R5 unexpected output: hv=%b bv=%b ur=%b cpl=%b expected none",
                   a.hv, a.bv, a.ur, a.cpl);
        end else begin
          logic bad;
          x = expQ.pop_front();
          bad = (a.hv != x.hv) || (a.bv != x.bv) || (a.ur != x.ur) || (a.cpl != x.cpl) ||
                (a.bar != x.bar) ||
                ((x.hv != 0) && (a.hdr != x.hdr)) ||
                ((x.bv != 0) && ((a.data != x.data) || (a.sop != x.sop) || (a.eop != x.eop)));
          if (bad) begin
            nFails++;
            $display("FAIL %s: hv=%b bar=%b bv=%b sop=%b eop=%b data=%h ur=%b cpl=%b hdr=%h expected hv=%b bar=%b bv=%b sop=%b eop=%b data=%h ur=%b cpl=%b hdr=%h",
                     x.req, a.hv, a.bar, a.bv, a.sop, a.eop, a.data, a.ur, a.cpl, a.hdr,
                     x.hv, x.bar, x.bv, x.sop, x.eop, x.data, x.ur, x.cpl, x.hdr);
          end
        end
      end
    end
  end

  // Watchdog
  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 20000) begin
        nChecks++; nFails++;
        $display("FAIL watchdog: cycles=%0d expected completion before 20000", cyc);
        $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
        $finish;
      end
    end
  end

  initial begin
    ev_t e;
    logic [127:0] hA, hB;
    repeat (3) @(negedge clk);
    // R10 reset state
    nChecks++;
    if ({appHdrValid, cfgHdrValid, msgHdrValid, appBarHit, appBeatValid, cfgBeatValid,
         msgBeatValid, beatOutSop, beatOutEop, urErr, cplReq} != 0) begin
      nFails++;
      $display("FAIL R10 reset outputs nonzero: got %b expected 0",
               {appHdrValid, cfgHdrValid, msgHdrValid, appBarHit, urErr, cplReq});
    end
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R1 memory read, 3DW, BAR0
    sendPkt(mkHdr(32'h0000_0001, 32'h0, 32'h8000_0010, 32'h0), 0, 0, 3'b001, 0, 0, "R1 mrd bar0");
    sendPkt(mkHdr(32'h0000_0001, 32'h0, 32'h8000_0FFC, 32'h0), 0, 0, 3'b001, 0, 0, "R1 mrd bar0 top");
    // R5 just outside BAR0
    sendPkt(mkHdr(32'h0000_0001, 32'h0, 32'h8000_1000, 32'h0), 0, 3, 3'b000, 1, 1, "R5 mrd past bar0");
    // R8 memory write, two beats
    sendPkt(mkHdr(32'h4000_0002, 32'h0, 32'h8000_0020, 32'h0), 2, 0, 3'b001, 0, 0, "R8 mwr bar0");
    // R2 4DW write into BAR1
    sendPkt(mkHdr(32'h6000_0001, 32'h0, 32'h0000_0010, 32'h0000_0100), 1, 0, 3'b010, 0, 0, "R2 mwr4 bar1");
    // R2 upper word off by one
    sendPkt(mkHdr(32'h2000_0001, 32'h0, 32'h0000_0011, 32'h0000_0100), 0, 3, 3'b000, 1, 1, "R2 mrd4 miss");
    // R1 I/O read/write to BAR2
    sendPkt(mkHdr(32'h0200_0001, 32'h0, 32'h0000_1004, 32'h0), 0, 0, 3'b100, 0, 0, "R1 iord bar2");
    sendPkt(mkHdr(32'h4200_0001, 32'h0, 32'h0000_1008, 32'h0), 1, 0, 3'b100, 0, 0, "R1 iowr bar2");
    // R1 kind mismatch both ways
    sendPkt(mkHdr(32'h0200_0001, 32'h0, 32'h8000_0010, 32'h0), 0, 3, 3'b000, 1, 1, "R1 io to mem bar");
    sendPkt(mkHdr(32'h0000_0001, 32'h0, 32'h0000_1004, 32'h0), 0, 3, 3'b000, 1, 1, "R1 mem to io bar");
    // R3 config type 0
    sendPkt(mkHdr(32'h0400_0001, 32'h0100_000F, 32'h0000_0010, 32'h0), 0, 1, 3'b000, 0, 0, "R3 cfg0 rd");
    sendPkt(mkHdr(32'h4400_0001, 32'h0100_000F, 32'h0000_0014, 32'h0), 1, 1, 3'b000, 0, 0, "R3 cfg0 wr");
    // R7 config type 1 dropped non-posted
    sendPkt(mkHdr(32'h0500_0001, 32'h0100_000F, 32'h0000_0010, 32'h0), 0, 3, 3'b000, 1, 1, "R7 cfg1 rd");
    // R4 messages
    sendPkt(mkHdr(32'h3000_0000, 32'h0000_0014, 32'h0, 32'h0), 0, 2, 3'b000, 0, 0, "R4 msg 14");
    sendPkt(mkHdr(32'h3400_0000, 32'h0000_0018, 32'h0, 32'h0), 0, 2, 3'b000, 0, 0, "R4 msg 18");
    sendPkt(mkHdr(32'h3300_0000, 32'h0000_0019, 32'h0, 32'h0), 0, 2, 3'b000, 0, 0, "R4 msg 19");
    sendPkt(mkHdr(32'h3000_0000, 32'h0000_001B, 32'h0, 32'h0), 0, 2, 3'b000, 0, 0, "R4 msg 1B");
    sendPkt(mkHdr(32'h7400_0001, 32'h0000_0050, 32'h0, 32'h0), 1, 2, 3'b000, 0, 0, "R4 msg 50 data");
    // R6 unsupported message codes: pulse, no completion, payload dropped
    sendPkt(mkHdr(32'h3000_0000, 32'h0000_0020, 32'h0, 32'h0), 0, 3, 3'b000, 1, 0, "R6 msg 20");
    sendPkt(mkHdr(32'h7000_0001, 32'h0000_0051, 32'h0, 32'h0), 2, 3, 3'b000, 1, 0, "R6 msg 51 data");
    // R6 dropped posted write: no output at all
    sendPkt(mkHdr(32'h4000_0002, 32'h0, 32'h9000_0000, 32'h0), 2, 3, 3'b000, 0, 0, "R6 mwr miss");
    // R5 completion type dropped silently
    sendPkt(mkHdr(32'h4A00_0001, 32'h0, 32'h0, 32'h0), 1, 3, 3'b000, 0, 0, "R5 cpl type");
    // R8 stray beat with no decision, and after a header-only packet
    strayBeat();
    sendPkt(mkHdr(32'h0000_0001, 32'h0, 32'h8000_0040, 32'h0), 0, 0, 3'b001, 0, 0, "R8 hdr only");
    strayBeat();

    // R9 eop beat and next header in same cycle
    hA = mkHdr(32'h4000_0002, 32'h0, 32'h8000_0080, 32'h0);
    hB = mkHdr(32'h0400_0001, 32'h0200_0000, 32'h0000_0020, 32'h0);
    @(negedge clk);
    hdrValid = 1; hdrData = hA;
    e = blankEv("R9 hdr A"); e.hv = 3'b001; e.bar = 3'b001; e.hdr = hA; expQ.push_back(e);
    @(negedge clk);
    hdrValid = 0; beatValid = 1; beatSop = 1; beatEop = 0; beatData = 64'h1111;
    e = blankEv("R9 beat A0"); e.bv = 3'b001; e.sop = 1; e.data = 64'h1111; expQ.push_back(e);
    @(negedge clk);
    hdrValid = 1; hdrData = hB; beatValid = 1; beatSop = 0; beatEop = 1; beatData = 64'h2222;
    e = blankEv("R9 eop A with hdr B"); e.bv = 3'b001; e.eop = 1; e.data = 64'h2222;
    e.hv = 3'b010; e.hdr = hB; expQ.push_back(e);
    @(negedge clk);
    hdrValid = 0; beatValid = 0; beatEop = 0;
    strayBeat();

    repeat (5) @(negedge clk);
    nChecks++;
    if (expQ.size() != 0) begin
      nFails++;
      $display("FAIL R8 missing outputs: %0d pending expected 0 (first %s)",
               expQ.size(), expQ[0].req);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule